// File: doc/BRIEF.md
# GPIO Input Event Router

A bank of general-purpose pins, sized by parameter up to 95, that watches its pin inputs and turns them into events for five system destinations. These are the interrupt request, the system-control interrupt, the non-maskable interrupt, the management-mode interrupt and the wake signal. Each pin passes through a two-flop synchroniser. Software then chooses per pin whether it reacts to a level or to an edge, and in which polarity. Every destination output is the OR, across the pins allowed to reach it, of the pin's event status ANDed with that pin's enable for that destination.

Eligibility differs by destination. Any pin may reach the interrupt and system-control outputs. Only a fixed window of pins (32 to 47 by default) may reach the non-maskable and management-mode outputs. Only pins flagged in a per-pin well vector may reach wake. The same bank drives pin outputs, and the lower 32 pins may blink under a shared prescaler.

Software reaches the bank through a flat register port. Each pin has one 32-bit word at address `pin` (address bit 7 clear). The blink half-period, counted in clock cycles, sits at address 0x80. Writes take effect on the clock edge. Reads are combinational.

Top module: `gpio_evt_router`

## Requirements
- R1: After reset every destination output and every `pad_oe` bit is 0, every pin word reads 0 except pin 31, whose bit 0 reads 1, and address 0x80 reads the reset half-period (4).
- R2: The sampled input (pin word bit 16) shows a pin change two clock edges after the change, and the resulting status (bit 17) and destination outputs change one edge later.
- R3: With bit 5 = 0 (level mode), status equals the synchronised input XOR the polarity bit 6 while the pin is active, and writing 1 to bit 17 has no effect on it.
- R4: With bit 5 = 1 (edge mode), status becomes 1 on a rising edge of the input when bit 6 = 0, or on a falling edge when bit 6 = 1. It stays 1 until a write with bit 17 = 1 clears it. If an edge and the clear fall in the same cycle, the status stays set.
- R5: A pin is active only when bit 0 (GPIO mode) = 1 and bit 4 (sense disable) = 0. An inactive pin reads 0 in bit 16 and creates no new events.
- R6: `irq_o` is the OR over all pins of status AND bit 7. `sci_o` is the same with bit 8.
- R7: `nmi_o` (bit 9) and `smi_o` (bit 10) can be raised only by pins NMI_LO..NMI_HI. On any other pin those enable bits read 0 after a write of 1.
- R8: `wake_o` (enable bit 11) can be raised only by pins whose WAKE_WELL bit is 1. On other pins bit 11 reads 0.
- R9: `pad_oe` of a pin equals bit 0 AND bit 1 (direction out), and `pad_out` carries bit 2 while the pad is driven.
- R10: For pins below 32 with bit 3 (blink) = 1, `pad_out` toggles every half-period clock cycles, in phase across pins. On higher pins bit 3 reads 0 and the output stays steady.
- R11: Writes to bit 0 of pin 31 are ignored. That bit always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NPINS | Raw pin inputs, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| pad_out | output | NPINS | Driven pin levels |
| pad_oe | output | NPINS | Pin output enables |
| irq_o | output | 1 | Interrupt request |
| sci_o | output | 1 | System-control interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |
| smi_o | output | 1 | Management-mode interrupt |
| wake_o | output | 1 | Wake request |

## Verification
The main collision is a software clear of an edge-mode status landing on the same clock edge as a fresh input edge on that pin. The bench times the pin change so that the edge reaches detection exactly on the clock edge that performs the clear write, and the design must keep the status set. A second overlap comes from writing the clear bit to a level-mode pin while its input is still asserted. This is judged by the interrupt output staying high on the following cycles.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;
  // Per-pin configuration, bit 0 (sel) is the LSB of the pin word.
  typedef struct packed {
    logic wake;
    logic smi;
    logic nmi;
    logic sci;
    logic irq;
    logic pol;
    logic edge_m;
    logic dis;
    logic blink;
    logic outv;
    logic dir;
    logic sel;
  } pin_cfg_t;

  localparam int CFG_BITS = $bits(pin_cfg_t);
  localparam int IN_BIT   = 16;
  localparam int STS_BIT  = 17;

  function automatic bit in_window(int idx, int lo, int hi);
    return (idx >= lo) && (idx <= hi);
  endfunction

  // Edge of (value XOR polarity) from 0 to 1.
  function automatic logic edge_seen(logic cur, logic prv, logic pol);
    return (cur ^ pol) & ~(prv ^ pol);
  endfunction

  function automatic logic [31:0] pack_word(pin_cfg_t c, logic in_v, logic sts);
    return {14'd0, sts, in_v, 4'd0, c};
  endfunction
endpackage

// File: rtl/gpio_evt_sync.sv
`timescale 1ns/1ps
module gpio_evt_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/gpio_evt_blink.sv
`timescale 1ns/1ps
module gpio_evt_blink #(
  parameter int HPW      = 16,
  parameter int HP_RESET = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hp_we,
  input  logic [HPW-1:0] hp_wd,
  output logic [HPW-1:0] hp_q,
  output logic           phase
);
  logic [HPW-1:0] cnt_q;
  logic [HPW-1:0] limit;
  logic           wrap;

  assign limit = (hp_q == '0) ? '0 : hp_q - 1'b1;
  assign wrap  = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q  <= HPW'(HP_RESET);
      cnt_q <= '0;
      phase <= 1'b0;
    end else begin
      if (hp_we) hp_q <= hp_wd;
      if (wrap) begin
        cnt_q <= '0;
        phase <= ~phase;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> (cnt_q == '0)); // R10
endmodule

// File: rtl/gpio_evt_pin.sv
`timescale 1ns/1ps
module gpio_evt_pin
  import gpio_evt_pkg::*;
#(
  parameter bit CAN_NMI   = 1'b0,
  parameter bit CAN_BLINK = 1'b0,
  parameter bit CAN_WAKE  = 1'b0,
  parameter bit SEL_FIXED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  pin_cfg_t    wr_cfg,
  input  logic        wr_clr,
  input  logic        sync_in,
  input  logic        blink_phase,
  output logic [31:0] rd_word,
  output logic        sts,
  output logic        ev_irq,
  output logic        ev_sci,
  output logic        ev_nmi,
  output logic        ev_smi,
  output logic        ev_wake,
  output logic        pad_out,
  output logic        pad_oe
);
  pin_cfg_t cfg_q, cfg_d;
  logic prev_q, sts_q;
  logic active, lvl_hit, edge_hit, clr_hit, in_view;

  always_comb begin
    cfg_d       = wr_cfg;
    cfg_d.sel   = wr_cfg.sel | SEL_FIXED;
    cfg_d.nmi   = wr_cfg.nmi & CAN_NMI;
    cfg_d.smi   = wr_cfg.smi & CAN_NMI;
    cfg_d.wake  = wr_cfg.wake & CAN_WAKE;
    cfg_d.blink = wr_cfg.blink & CAN_BLINK;
  end

  assign active   = cfg_q.sel & ~cfg_q.dis;
  assign in_view  = sync_in & active;
  assign lvl_hit  = active & (sync_in ^ cfg_q.pol);
  assign edge_hit = active & cfg_q.edge_m & edge_seen(sync_in, prev_q, cfg_q.pol);
  assign clr_hit  = wr_en & wr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cfg_q.sel <= SEL_FIXED;
      prev_q    <= 1'b0;
      sts_q     <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_d;
      prev_q <= sync_in;
      if (!cfg_q.edge_m)  sts_q <= lvl_hit;
      else if (edge_hit)  sts_q <= 1'b1;
      else if (clr_hit)   sts_q <= 1'b0;
    end
  end

  assign sts     = sts_q;
  assign ev_irq  = sts_q & cfg_q.irq;
  assign ev_sci  = sts_q & cfg_q.sci;
  assign ev_nmi  = sts_q & cfg_q.nmi;
  assign ev_smi  = sts_q & cfg_q.smi;
  assign ev_wake = sts_q & cfg_q.wake;
  assign pad_oe  = cfg_q.sel & cfg_q.dir;
  assign pad_out = pad_oe & (cfg_q.outv ^ (cfg_q.blink & blink_phase));
  assign rd_word = pack_word(cfg_q, in_view, sts_q);

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> sts_q); // R4
  AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && cfg_q.edge_m && !edge_hit) |=> !sts_q); // R4
  AST_LEVEL_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !cfg_q.edge_m && lvl_hit) |=> sts_q); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cfg_q.dis && !cfg_q.edge_m) |=> !sts_q); // R5
endmodule

// File: rtl/gpio_evt_router.sv
`timescale 1ns/1ps
module gpio_evt_router
  import gpio_evt_pkg::*;
#(
  parameter int          NPINS      = 48,
  parameter int          HPW        = 16,
  parameter int          HP_RESET   = 4,
  parameter int          NMI_LO     = 32,
  parameter int          NMI_HI     = 47,
  parameter int          BLINK_PINS = 32,
  parameter int          FIXED_PIN  = 31,
  parameter logic [94:0] WAKE_WELL  = 95'h0000FF000000FF00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [7:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq_o,
  output logic             sci_o,
  output logic             nmi_o,
  output logic             smi_o,
  output logic             wake_o
);
  localparam int IDXW = 7;

  logic [NPINS-1:0] sync_q, pin_we, sts_vec;
  logic [NPINS-1:0] ev_irq, ev_sci, ev_nmi, ev_smi, ev_wake;
  logic [NPINS-1:0] nmi_mask, wake_mask;
  logic [31:0]      rd_word [NPINS];
  logic [HPW-1:0]   hp_q;
  logic             phase, hp_we;
  pin_cfg_t         wr_cfg;
  logic             unused_wr_bits;

  assign wr_cfg         = pin_cfg_t'(wr_data[CFG_BITS-1:0]);
  assign hp_we          = wr_en & wr_addr[7] & (wr_addr[IDXW-1:0] == '0);
  assign unused_wr_bits = ^{wr_data[31:18], wr_data[IN_BIT]};

  gpio_evt_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q));

  gpio_evt_blink #(.HPW(HPW), .HP_RESET(HP_RESET)) u_blink (
    .clk(clk), .rst_n(rst_n), .hp_we(hp_we), .hp_wd(wr_data[HPW-1:0]),
    .hp_q(hp_q), .phase(phase));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam bit NMI_OK = in_window(i, NMI_LO, NMI_HI);
    localparam bit BL_OK  = (i < BLINK_PINS);
    localparam bit WK_OK  = WAKE_WELL[i];
    localparam bit FIX    = (i == FIXED_PIN);

    assign pin_we[i]    = wr_en & ~wr_addr[7] & (wr_addr[IDXW-1:0] == IDXW'(i));
    assign nmi_mask[i]  = NMI_OK;
    assign wake_mask[i] = WK_OK;

    gpio_evt_pin #(
      .CAN_NMI(NMI_OK), .CAN_BLINK(BL_OK), .CAN_WAKE(WK_OK), .SEL_FIXED(FIX)
    ) u_pin (
      .clk(clk), .rst_n(rst_n), .wr_en(pin_we[i]), .wr_cfg(wr_cfg),
      .wr_clr(wr_data[STS_BIT]), .sync_in(sync_q[i]), .blink_phase(phase),
      .rd_word(rd_word[i]), .sts(sts_vec[i]),
      .ev_irq(ev_irq[i]), .ev_sci(ev_sci[i]), .ev_nmi(ev_nmi[i]),
      .ev_smi(ev_smi[i]), .ev_wake(ev_wake[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i]));
  end

  assign irq_o  = |ev_irq;
  assign sci_o  = |ev_sci;
  assign nmi_o  = |ev_nmi;
  assign smi_o  = |ev_smi;
  assign wake_o = |ev_wake;

  always_comb begin
    rd_data = '0;
    if (rd_addr[7]) begin
      if (rd_addr[IDXW-1:0] == '0) rd_data = 32'(hp_q);
    end else begin
      for (int i = 0; i < NPINS; i++)
        if (rd_addr[IDXW-1:0] == IDXW'(i)) rd_data = rd_word[i];
    end
  end

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|sts_vec)); // R6
  AST_NMI_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o || smi_o) |-> (|(sts_vec & nmi_mask))); // R7
  AST_WAKE_WELL: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (|(sts_vec & wake_mask))); // R8
endmodule

// File: tb/sim_gpio_evt_router.sv
`timescale 1ns/1ps
module sim_gpio_evt_router;
  localparam int NP = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq_o, sci_o, nmi_o, smi_o, wake_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_evt_router u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_o(irq_o), .sci_o(sci_o), .nmi_o(nmi_o), .smi_o(smi_o),
    .wake_o(wake_o));

  localparam logic [31:0] SEL = 32'h1, DIR = 32'h2, OUTV = 32'h4, BLK = 32'h8;
  localparam logic [31:0] DIS = 32'h10, EDG = 32'h20, POL = 32'h40, IRQ = 32'h80;
  localparam logic [31:0] SCI = 32'h100, NMI = 32'h200, SMI = 32'h400, WAK = 32'h800;
  localparam logic [31:0] CLR = 32'h20000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); pin_in[p] = v;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk); #1;
  endtask

  task automatic park(input int p);
    set_pin(p, 1'b0);
    wr(8'(p), CLR);
    cyc(4);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", irq_o, 0); chk("R1 sci", sci_o, 0); chk("R1 nmi", nmi_o, 0);
    chk("R1 smi", smi_o, 0); chk("R1 wake", wake_o, 0); chk("R1 oe", 32'(pad_oe), 0);
    rd(8'd0, d);  chk("R1 pin0 word", d, 0);
    rd(8'd31, d); chk("R1 pin31 word", d, 32'h1);
    rd(8'h80, d); chk("R1 half-period", d, 32'd4);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    wr(8'd5, SEL | IRQ);
    set_pin(5, 1'b1);
    cyc(1); rd(8'd5, d); chk("R2 sampled after 1", 32'(d[16]), 0);
    cyc(1); rd(8'd5, d); chk("R2 sampled after 2", 32'(d[16]), 1);
    chk("R2 irq after 2", irq_o, 0);
    cyc(1); chk("R2 irq after 3", irq_o, 1);
  endtask

  task automatic t_level;
    wr(8'd5, SEL | IRQ | CLR);
    cyc(2); chk("R3 clear ignored in level", irq_o, 1);
    wr(8'd5, SEL | IRQ | POL);
    cyc(1); chk("R3 inverted polarity", irq_o, 0);
    set_pin(5, 1'b0); cyc(3); chk("R3 low input with pol", irq_o, 1);
    park(5); chk("R3 parked", irq_o, 0);
  endtask

  task automatic t_edge;
    wr(8'd6, SEL | IRQ | EDG);
    set_pin(6, 1'b1); cyc(3); chk("R4 rising sets", irq_o, 1);
    set_pin(6, 1'b0); cyc(4); chk("R4 sticky after drop", irq_o, 1);
    wr(8'd6, SEL | IRQ | EDG | CLR); chk("R4 w1c clears", irq_o, 0);
    wr(8'd6, SEL | IRQ | EDG | POL);
    set_pin(6, 1'b1); cyc(3); chk("R4 rising ignored with pol", irq_o, 0);
    set_pin(6, 1'b0); cyc(3); chk("R4 falling sets with pol", irq_o, 1);
    wr(8'd6, SEL | IRQ | EDG | CLR); chk("R4 cleared again", irq_o, 0);
    // collision: edge reaches detection on the clear-write edge
    set_pin(6, 1'b1);
    @(posedge clk); @(posedge clk);
    wr(8'd6, SEL | IRQ | EDG | CLR);
    chk("R4 edge beats clear", irq_o, 1);
    cyc(2); chk("R4 still set", irq_o, 1);
    park(6); chk("R4 parked", irq_o, 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(8'd7, SEL | IRQ | DIS);
    set_pin(7, 1'b1); cyc(3);
    rd(8'd7, d); chk("R5 disabled reads 0", 32'(d[16]), 0);
    chk("R5 disabled no irq", irq_o, 0);
    wr(8'd7, SEL | IRQ); cyc(1);
    rd(8'd7, d); chk("R5 enabled reads 1", 32'(d[16]), 1);
    chk("R5 enabled irq", irq_o, 1);
    wr(8'd7, IRQ); cyc(1);
    rd(8'd7, d); chk("R5 native reads 0", 32'(d[16]), 0);
    chk("R5 native no irq", irq_o, 0);
    park(7);
  endtask

  task automatic t_sci;
    wr(8'd2, SEL | SCI);
    set_pin(2, 1'b1); cyc(3);
    chk("R6 sci", sci_o, 1); chk("R6 irq off", irq_o, 0);
    park(2); chk("R6 sci parked", sci_o, 0);
  endtask

  task automatic t_nmi;
    logic [31:0] d;
    wr(8'd10, SEL | NMI | SMI);
    rd(8'd10, d); chk("R7 enables tied low outside window", d & 32'h600, 0);
    set_pin(10, 1'b1); cyc(3);
    chk("R7 nmi outside", nmi_o, 0); chk("R7 smi outside", smi_o, 0);
    wr(8'd40, SEL | NMI | SMI);
    set_pin(40, 1'b1); cyc(3);
    chk("R7 nmi inside", nmi_o, 1); chk("R7 smi inside", smi_o, 1);
    park(10); park(40);
  endtask

  task automatic t_wake;
    logic [31:0] d;
    wr(8'd20, SEL | WAK);
    rd(8'd20, d); chk("R8 wake bit tied low", 32'(d[11]), 0);
    set_pin(20, 1'b1); cyc(3); chk("R8 no wake outside well", wake_o, 0);
    wr(8'd9, SEL | WAK);
    set_pin(9, 1'b1); cyc(3); chk("R8 wake from well pin", wake_o, 1);
    park(20); park(9);
  endtask

  task automatic t_out;
    wr(8'd3, SEL | DIR | OUTV);
    chk("R9 oe", 32'(pad_oe[3]), 1); chk("R9 out high", 32'(pad_out[3]), 1);
    wr(8'd3, SEL | DIR);
    chk("R9 out low", 32'(pad_out[3]), 0);
    wr(8'd3, DIR | OUTV);
    chk("R9 native no oe", 32'(pad_oe[3]), 0);
  endtask

  task automatic t_blink;
    logic [31:0] d;
    logic pv;
    int n;
    wr(8'h80, 32'd3);
    rd(8'h80, d); chk("R10 half-period readback", d, 3);
    wr(8'd3, SEL | DIR | OUTV | BLK);
    wr(8'd4, SEL | DIR | OUTV | BLK);
    @(negedge clk); pv = pad_out[3]; n = 0;
    while (pad_out[3] == pv && n < 20) begin @(negedge clk); n++; end
    for (int k = 0; k < 2; k++) begin
      pv = pad_out[3]; n = 0;
      do begin @(negedge clk); n++; end while (pad_out[3] == pv && n < 20);
      chk("R10 toggle interval", n, 3);
      chk("R10 pins in phase", 32'(pad_out[4]), 32'(pad_out[3]));
    end
    wr(8'd35, SEL | DIR | OUTV | BLK);
    rd(8'd35, d); chk("R10 blink tied low above 32", 32'(d[3]), 0);
    n = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (pad_out[35] !== 1'b1) n++; end
    chk("R10 high pin steady", n, 0);
    wr(8'd3, 0); wr(8'd4, 0); wr(8'd35, 0);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    wr(8'd31, 32'h0);
    rd(8'd31, d); chk("R11 mode bit stays 1", 32'(d[0]), 1);
    wr(8'd31, DIR | OUTV);
    chk("R11 drives with forced mode", 32'(pad_oe[31]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_sync();
    t_level();
    t_edge();
    t_disable();
    t_sci();
    t_nmi();
    t_wake();
    t_out();
    t_blink();
    t_fixed();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule